// File: doc/BRIEF.md
# Sleep-Mode Interrupt Recorder

This block sits beside a bank of external interrupt lines and keeps a record of which lines fired while the main interrupt controller is powered down. Each line has its own mask, polarity and sensitivity setting. A line that meets its trigger condition sets a sticky status bit. This happens whether or not the block is globally enabled, and whether or not the line is masked. When the system wakes, software issues a flush. Every latched and unmasked line then sends a single-cycle pulse toward the parent controller, so a wake-up event cannot be lost across the power transition.

Software reaches the block through a simple register bus. Per-line settings are packed 32 lines to a 32-bit word, and each setting has its own set address and its own clear address. Status is cleared by writing ones to an acknowledge address. A control word holds three bits: global enable, an edge-only capture mode, and a flush trigger. The request channel follows valid/ready rules, but `reg_ready` is held high, so a request is taken on every cycle in which `reg_valid` is high. The response channel has no back-pressure: `rsp_valid` is high for exactly one cycle, one cycle after a read is accepted, and the requester must take the data in that cycle.

Top module: `irq_sleep_recorder`

## Requirements
- R1: Line n is held in bit (n mod 32) of the word at group base + (n/32)*4. With `ALT_LAYOUT`=0 the group bases are status 0x000, acknowledge 0x040, mask-set 0x0C0, mask-clear 0x100, sensitivity-set 0x180, sensitivity-clear 0x1C0, polarity-set 0x240, polarity-clear 0x280 and control 0x300. With `ALT_LAYOUT`=1 they are 0x000, 0x080, 0x180, 0x200, 0x300, 0x380, 0x480, 0x500 and 0x600, in the same group order.
- R2: Writes to a set address or a clear address change only the lines whose data bit is 1; zero bits leave those lines unchanged. A read of either the set address or the clear address of a group returns that group's current word.
- R3: A polarity bit of 1 selects active-high or rising edge, and 0 selects active-low or falling edge. A sensitivity bit of 1 selects level triggering, and 0 selects edge triggering. A level line latches status on every cycle in which its synchronized input equals its polarity bit. An edge line latches status when the synchronized input differs from its one-cycle-delayed copy in the configured direction.
- R4: While the edge-only bit is set, every line is captured on its configured edge, whatever its sensitivity bit holds. A held level no longer re-latches status.
- R5: Status is latched while the enable bit is 0, and it is latched for masked lines.
- R6: Writing 1 to a line's bit at the acknowledge address clears that line's status. If a capture occurs in the same cycle, the capture wins. Reads of the acknowledge address return 0.
- R7: A flush sets `replay_out` to status AND NOT mask for exactly one cycle, in the cycle after the write is accepted. The replayed status bits are cleared at that write. Latched masked lines keep their status.
- R8: In the control word, bit 0 is enable, bit 1 is edge-only mode and bit 2 is flush. The flush bit reads back as 0. A flush acts only when the same write also sets bit 0; otherwise `replay_out` stays 0 and status is unchanged.
- R9: After reset, all lines are masked, sensitivity and polarity are 0, status is 0, the control word reads 0 and `replay_out` is 0.
- R10: `reg_ready` is 1. `rsp_valid` is 1 exactly in the cycle after an accepted read. Reads of unmapped addresses return 0, and writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Request accepted (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| lines_in | input | NUM_LINES | External interrupt lines |
| replay_out | output | NUM_LINES | Replay pulses toward the parent controller |

## Verification
A wrong status bit can stay hidden until software reads the status word, or until a flush emits a pulse that is missing or unexpected. For that reason the bench reads every status word and every configuration word after each operation, and it compares `replay_out` in the exact cycle that follows each flush write. A capture path that fails to re-latch a held level, or that re-latches one in edge-only mode, shows up in the first status read after an acknowledge. A replay pulse that lasts too long appears one cycle after the flush.

// File: rtl/irqrec_pkg.sv
package irqrec_pkg;

  typedef enum logic [3:0] {
    GRP_STAT = 4'd0,
    GRP_ACK  = 4'd1,
    GRP_MSET = 4'd2,
    GRP_MCLR = 4'd3,
    GRP_SSET = 4'd4,
    GRP_SCLR = 4'd5,
    GRP_PSET = 4'd6,
    GRP_PCLR = 4'd7,
    GRP_CTRL = 4'd8,
    GRP_NONE = 4'd15
  } grp_e;

  localparam int NUM_GRP        = 9;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_EDGE_BIT  = 1;
  localparam int CTRL_FLUSH_BIT = 2;

  // byte offset of each register group, in group order
  function automatic logic [11:0] grp_base(input bit alt, input int g);
    case (g)
      0:       return 12'h000;
      1:       return alt ? 12'h080 : 12'h040;
      2:       return alt ? 12'h180 : 12'h0C0;
      3:       return alt ? 12'h200 : 12'h100;
      4:       return alt ? 12'h300 : 12'h180;
      5:       return alt ? 12'h380 : 12'h1C0;
      6:       return alt ? 12'h480 : 12'h240;
      7:       return alt ? 12'h500 : 12'h280;
      8:       return alt ? 12'h600 : 12'h300;
      default: return 12'hFFF;
    endcase
  endfunction

endpackage

// File: rtl/irqrec_decode.sv
module irqrec_decode
  import irqrec_pkg::*;
#(
  parameter int NUM_LINES  = 40,
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int ADDR_W     = 12
) (
  input  logic [ADDR_W-1:0]                                   addr,
  output grp_e                                                grp,
  output logic [((NUM_LINES+31)/32 > 1 ? $clog2((NUM_LINES+31)/32) : 1)-1:0] widx
);
  localparam int WORDS  = (NUM_LINES + 31) / 32;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * 4);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;

  always_comb begin
    grp  = GRP_NONE;
    widx = '0;
    base = '0;
    off  = '0;
    for (int g = 0; g < NUM_GRP - 1; g++) begin
      base = ADDR_W'(grp_base(ALT_LAYOUT, g));
      off  = addr - base;
      if ((addr >= base) && (off < SPAN) && (off[1:0] == 2'b00)) begin
        grp  = grp_e'(4'(g));
        widx = off[WIDX_W+1:2];
      end
    end
    if (addr == ADDR_W'(grp_base(ALT_LAYOUT, NUM_GRP - 1)))
      grp = GRP_CTRL;
  end

endmodule

// File: rtl/irqrec_sync.sv
module irqrec_sync #(
  parameter int NUM_LINES   = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] cur,
  output logic [NUM_LINES-1:0] prev
);
  logic [NUM_LINES-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= lines_in;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign cur = stg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

endmodule

// File: rtl/irqrec_bits.sv
module irqrec_bits #(
  parameter int                   NUM_LINES = 40,
  parameter logic [NUM_LINES-1:0] RST_VAL   = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_vec,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/irqrec_capture.sv
module irqrec_capture #(
  parameter int NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] cur,
  input  logic [NUM_LINES-1:0] prev,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] sens,
  input  logic [NUM_LINES-1:0] mask,
  input  logic                 edge_only,
  input  logic [NUM_LINES-1:0] ack_vec,
  input  logic                 flush_go,
  output logic [NUM_LINES-1:0] event_vec,
  output logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] replay
);
  logic [NUM_LINES-1:0] level_mode, lvl_hit, edge_hit, fire;

  always_comb begin
    level_mode = sens & ~{NUM_LINES{edge_only}};
    lvl_hit    = ~(cur ^ pol);
    edge_hit   = (pol & cur & ~prev) | (~pol & ~cur & prev);
    event_vec  = (level_mode & lvl_hit) | (~level_mode & edge_hit);
    fire       = flush_go ? (status & ~mask) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      replay <= '0;
    end else begin
      status <= (status & ~ack_vec & ~fire) | event_vec;
      replay <= fire;
    end
  end

endmodule

// File: rtl/irq_sleep_recorder.sv
module irq_sleep_recorder
  import irqrec_pkg::*;
#(
  parameter int NUM_LINES   = 40,
  parameter bit ALT_LAYOUT  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  output logic                 reg_ready,
  input  logic                 reg_write,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] replay_out
);
  localparam int WORDS  = (NUM_LINES + 31) / 32;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  grp_e                 grp;
  logic [WIDX_W-1:0]    widx;
  logic                 wr_go, rd_go;
  logic [NUM_LINES-1:0] wvec;
  logic [NUM_LINES-1:0] mask_set, mask_clr, sens_set, sens_clr, pol_set, pol_clr;
  logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, status_q, ack_vec, event_vec;
  logic [NUM_LINES-1:0] cur, prev;
  logic                 en_q, edge_q, flush_go;
  logic [31:0]          rdata_d;

  assign reg_ready = 1'b1;
  assign wr_go     = reg_valid & reg_write;
  assign rd_go     = reg_valid & ~reg_write;

  irqrec_decode #(
    .NUM_LINES (NUM_LINES),
    .ALT_LAYOUT(ALT_LAYOUT),
    .ADDR_W    (12)
  ) u_dec (
    .addr(reg_addr),
    .grp (grp),
    .widx(widx)
  );

  // place the write word onto the line vector
  for (genvar b = 0; b < NUM_LINES; b++) begin : g_wvec
    assign wvec[b] = (widx == WIDX_W'(b / 32)) ? reg_wdata[b % 32] : 1'b0;
  end

  assign mask_set = (wr_go && grp == GRP_MSET) ? wvec : '0;
  assign mask_clr = (wr_go && grp == GRP_MCLR) ? wvec : '0;
  assign sens_set = (wr_go && grp == GRP_SSET) ? wvec : '0;
  assign sens_clr = (wr_go && grp == GRP_SCLR) ? wvec : '0;
  assign pol_set  = (wr_go && grp == GRP_PSET) ? wvec : '0;
  assign pol_clr  = (wr_go && grp == GRP_PCLR) ? wvec : '0;
  assign ack_vec  = (wr_go && grp == GRP_ACK)  ? wvec : '0;

  irqrec_bits #(.NUM_LINES(NUM_LINES), .RST_VAL({NUM_LINES{1'b1}})) u_mask (
    .clk(clk), .rst_n(rst_n), .set_vec(mask_set), .clr_vec(mask_clr), .q(mask_q));
  irqrec_bits #(.NUM_LINES(NUM_LINES), .RST_VAL('0)) u_sens (
    .clk(clk), .rst_n(rst_n), .set_vec(sens_set), .clr_vec(sens_clr), .q(sens_q));
  irqrec_bits #(.NUM_LINES(NUM_LINES), .RST_VAL('0)) u_pol (
    .clk(clk), .rst_n(rst_n), .set_vec(pol_set), .clr_vec(pol_clr), .q(pol_q));

  // control word; flush needs the enable bit in the same write
  assign flush_go = wr_go && (grp == GRP_CTRL) &&
                    reg_wdata[CTRL_FLUSH_BIT] && reg_wdata[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
    end else if (wr_go && grp == GRP_CTRL) begin
      en_q   <= reg_wdata[CTRL_EN_BIT];
      edge_q <= reg_wdata[CTRL_EDGE_BIT];
    end
  end

  irqrec_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .cur(cur), .prev(prev));

  irqrec_capture #(.NUM_LINES(NUM_LINES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (cur),
    .prev     (prev),
    .pol      (pol_q),
    .sens     (sens_q),
    .mask     (mask_q),
    .edge_only(edge_q),
    .ack_vec  (ack_vec),
    .flush_go (flush_go),
    .event_vec(event_vec),
    .status   (status_q),
    .replay   (replay_out)
  );

  function automatic logic [31:0] pick(input logic [NUM_LINES-1:0] v,
                                       input logic [WIDX_W-1:0] w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (int'(w) * 32 + i < NUM_LINES) r[i] = v[int'(w) * 32 + i];
    end
    return r;
  endfunction

  always_comb begin
    rdata_d = '0;
    case (grp)
      GRP_STAT:           rdata_d = pick(status_q, widx);
      GRP_MSET, GRP_MCLR: rdata_d = pick(mask_q, widx);
      GRP_SSET, GRP_SCLR: rdata_d = pick(sens_q, widx);
      GRP_PSET, GRP_PCLR: rdata_d = pick(pol_q, widx);
      GRP_CTRL: begin
        rdata_d[CTRL_EN_BIT]   = en_q;
        rdata_d[CTRL_EDGE_BIT] = edge_q;
      end
      default:            rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      rsp_rdata <= rd_go ? rdata_d : '0;
    end
  end

endmodule

// File: rtl/irqrec_checker.sv
module irqrec_checker
  import irqrec_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_valid,
  input logic                 reg_write,
  input grp_e                 grp,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_LINES-1:0] replay_out,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] event_vec,
  input logic [NUM_LINES-1:0] ack_vec,
  input logic                 flush_go
);

  p_replay_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_out) |-> ((replay_out & $past(mask_q)) == '0));

  p_replay_from_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_out) |-> ((replay_out & ~$past(status_q)) == '0));

  p_replay_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_out) |-> ((status_q & replay_out & ~$past(event_vec)) == '0));

  p_replay_needs_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_out) |-> $past(flush_go));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec) |=> ((status_q & $past(ack_vec) & ~$past(event_vec)) == '0));

  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && grp == GRP_ACK) |=> (rsp_rdata == '0));

  p_flush_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && grp == GRP_CTRL) |=> (rsp_rdata[31:2] == '0));

  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> rsp_valid);

  p_rsp_only_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> !rsp_valid);

endmodule

bind irq_sleep_recorder irqrec_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .grp       (grp),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .replay_out(replay_out),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .event_vec (event_vec),
  .ack_vec   (ack_vec),
  .flush_go  (flush_go)
);

// File: tb/test_irq_sleep_recorder.sv
`timescale 1ns/1ps
module test_irq_sleep_recorder;
  localparam int N     = 40;
  localparam int WORDS = (N + 31) / 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_valid, reg_write, reg_ready, rsp_valid;
  logic [11:0]   reg_addr;
  logic [31:0]   reg_wdata, rsp_rdata;
  logic [N-1:0]  lines_in, replay_out;
  logic          a_valid, a_write, a_ready, a_rsp_valid;
  logic [11:0]   a_addr;
  logic [31:0]   a_wdata, a_rsp_rdata;
  logic [N-1:0]  a_replay;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the block state
  logic [N-1:0] m_mask, m_sens, m_pol, m_stat, m_lines;
  logic         m_en, m_edge;

  always #2.5 clk = ~clk;

  irq_sleep_recorder #(.NUM_LINES(N), .ALT_LAYOUT(1'b0)) i_irq_sleep_recorder (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lines_in(lines_in), .replay_out(replay_out));

  irq_sleep_recorder #(.NUM_LINES(N), .ALT_LAYOUT(1'b1)) i_irq_sleep_recorder_alt (
    .clk(clk), .rst_n(rst_n), .reg_valid(a_valid), .reg_ready(a_ready),
    .reg_write(a_write), .reg_addr(a_addr), .reg_wdata(a_wdata),
    .rsp_valid(a_rsp_valid), .rsp_rdata(a_rsp_rdata),
    .lines_in(lines_in), .replay_out(a_replay));

  function automatic logic [11:0] base(input int g);
    case (g)
      0: return 12'h000; 1: return 12'h040; 2: return 12'h0C0;
      3: return 12'h100; 4: return 12'h180; 5: return 12'h1C0;
      6: return 12'h240; 7: return 12'h280; default: return 12'h300;
    endcase
  endfunction

  function automatic logic [31:0] word_of(input logic [N-1:0] v, input int w);
    logic [63:0] t;
    t = 64'(v);
    return t[w*32 +: 32];
  endfunction

  function automatic logic [N-1:0] place(input logic [31:0] d, input int w);
    logic [63:0] t;
    t = 64'(d) << (32 * w);
    return t[N-1:0];
  endfunction

  function automatic logic [N-1:0] lvl_act(input logic edge_mode);
    return (m_sens & ~{N{edge_mode}}) & ~(m_lines ^ m_pol);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0;
    check("R10 rsp_valid after read", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic alt_write(input logic [11:0] a, input logic [31:0] d);
    a_valid = 1'b1; a_write = 1'b1; a_addr = a; a_wdata = d;
    @(posedge clk);
    @(negedge clk);
    a_valid = 1'b0; a_write = 1'b0;
  endtask

  task automatic alt_read(input logic [11:0] a, output logic [31:0] d);
    a_valid = 1'b1; a_write = 1'b0; a_addr = a;
    @(posedge clk);
    @(negedge clk);
    a_valid = 1'b0;
    d = a_rsp_rdata;
    @(negedge clk);
  endtask

  task automatic op_cfg(input int g, input int w, input logic [31:0] d);
    logic [N-1:0] v;
    bus_write(base(g) + 12'(4 * w), d);
    v = place(d, w);
    case (g)
      2: m_mask |= v;  3: m_mask &= ~v;
      4: m_sens |= v;  5: m_sens &= ~v;
      6: m_pol  |= v;  7: m_pol  &= ~v;
      default: ;
    endcase
    m_stat |= lvl_act(m_edge);
    settle();
  endtask

  task automatic op_lines(input logic [N-1:0] l);
    logic [N-1:0] old, edge_lines;
    old        = m_lines;
    m_lines    = l;
    lines_in   = l;
    edge_lines = ~(m_sens & ~{N{m_edge}});
    m_stat |= edge_lines & ((m_pol & l & ~old) | (~m_pol & ~l & old));
    m_stat |= lvl_act(m_edge);
    settle();
  endtask

  task automatic op_ack(input int w, input logic [31:0] d);
    bus_write(base(1) + 12'(4 * w), d);
    m_stat &= ~place(d, w);
    m_stat |= lvl_act(m_edge);
    settle();
  endtask

  task automatic op_ctrl(input logic [31:0] d);
    logic [N-1:0] rep;
    bus_write(base(8), d);
    rep = (d[2] && d[0]) ? (m_stat & ~m_mask) : '0;
    // R7/R8: replay pulse in the cycle after the write
    for (int w = 0; w < WORDS; w++)
      check("R7 replay pulse", word_of(replay_out, w), word_of(rep, w));
    m_stat = (m_stat & ~rep) | lvl_act(m_edge);
    m_en   = d[0];
    m_edge = d[1];
    @(negedge clk);
    for (int w = 0; w < WORDS; w++)
      check("R7 replay one cycle", word_of(replay_out, w), 32'd0);
    m_stat |= lvl_act(m_edge);
    settle();
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int w = 0; w < WORDS; w++) begin
      bus_read(base(0) + 12'(4 * w), d);
      check({tag, " R3 R5 status"}, d, word_of(m_stat, w));
      bus_read(base(2) + 12'(4 * w), d);
      check({tag, " R2 mask via set"}, d, word_of(m_mask, w));
      bus_read(base(3) + 12'(4 * w), d);
      check({tag, " R2 mask via clear"}, d, word_of(m_mask, w));
      bus_read(base(4) + 12'(4 * w), d);
      check({tag, " R2 sens"}, d, word_of(m_sens, w));
      bus_read(base(7) + 12'(4 * w), d);
      check({tag, " R2 pol"}, d, word_of(m_pol, w));
      bus_read(base(1) + 12'(4 * w), d);
      check({tag, " R6 ack reads 0"}, d, 32'd0);
    end
    bus_read(base(8), d);
    check({tag, " R8 control"}, d, {30'd0, m_edge, m_en});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    int unsigned seed_init;
    seed_init = $urandom(32'd917);
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    a_valid = 1'b0; a_write = 1'b0; a_addr = '0; a_wdata = '0;
    lines_in = '0;
    m_mask = '1; m_sens = '0; m_pol = '0; m_stat = '0; m_lines = '0;
    m_en = 1'b0; m_edge = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 replay after reset", word_of(replay_out, 0), 32'd0);
    check("R10 ready", 32'(reg_ready), 32'd1);
    check_all("R9 reset");

    // R2 unmask lines 0,1,4..7
    op_cfg(3, 0, 32'h0000_00F3);
    check_all("R2 unmask");

    // R3 R5 level-high line 4 while disabled
    op_cfg(6, 0, 32'h10);
    op_cfg(4, 0, 32'h10);
    op_lines(m_lines | place(32'h10, 0));
    check_all("R3 level high");

    // R3 falling edge on line 5: rise gives nothing, fall latches
    op_lines(m_lines | place(32'h20, 0));
    bus_read(base(0), d);
    check("R3 no capture on rise", d & 32'h20, 32'h0);
    op_lines(m_lines & ~place(32'h20, 0));
    check_all("R3 falling edge");

    // R6 ack: edge line clears, held level re-latches
    op_ack(0, 32'h30);
    check_all("R6 ack");

    // R8 flush without enable is ignored
    op_ctrl(32'h4);
    check_all("R8 flush gated");

    // R5 R7 masked line 0 latched, survives flush
    op_cfg(6, 0, 32'h1);
    op_cfg(2, 0, 32'h1);
    op_lines(m_lines | place(32'h1, 0));
    op_ctrl(32'h5);
    check_all("R7 flush");

    // R4 edge-only: held level no longer re-latches, edge does
    op_ctrl(32'h3);
    op_ack(0, 32'h10);
    check_all("R4 edge only ack");
    op_lines(m_lines & ~place(32'h10, 0));
    op_lines(m_lines | place(32'h10, 0));
    check_all("R4 edge only rise");
    op_ctrl(32'h1);

    // R1 line 33 lives in word 1 bit 1
    op_cfg(3, 1, 32'h2);
    op_cfg(6, 1, 32'h2);
    op_lines(m_lines | place(32'h2, 1));
    bus_read(base(0) + 12'd4, d);
    check("R1 line 33 status", d, word_of(m_stat, 1));
    check("R1 line 33 bit", d & 32'h2, 32'h2);

    // R10 unmapped addresses
    bus_read(12'h7F0, d);
    check("R10 unmapped read", d, 32'd0);
    bus_write(12'h7F0, 32'hFFFF_FFFF);
    bus_write(12'h0C8, 32'hFFFF_FFFF);
    settle();
    check_all("R10 unmapped write");

    // R1 alternate layout
    alt_write(12'h200, 32'h1);
    alt_read(12'h180, d);
    check("R1 alt mask", d, 32'hFFFF_FFFE);
    alt_read(12'h0C0, d);
    check("R1 alt old offset unmapped", d, 32'd0);
    alt_read(12'h600, d);
    check("R1 alt control", d, 32'd0);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 5)
        0: op_cfg(2 + int'($urandom % 6), int'($urandom % WORDS), $urandom);
        1: begin
          t = {$urandom, $urandom};
          op_lines(t[N-1:0]);
        end
        2: op_ack(int'($urandom % WORDS), $urandom);
        3: op_ctrl({29'd0, 1'b1, 1'($urandom % 2), 1'($urandom % 2)});
        default: op_lines(m_lines ^ place(32'h1 << ($urandom % 32), int'($urandom % WORDS)));
      endcase
      check_all("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule